// File: doc/BRIEF.md
# Overlapping Time-Frame Channel Multiplexer

This block collects 10-bit samples from 32 front-end channels and sends them out on one valid/ready stream, one time frame at a time. Samples arrive one per cycle at most, each tagged with its channel number, and go into a circular buffer for that channel. A frame covers the same window of sample numbers on every channel. The output walks a 32-slot routing table and, for each slot, sends a header word naming the channel and the frame's first sample number, then every sample of that channel in the window. After that it moves to the next slot. The table order lets channels be grouped by pad row, whatever the wiring.

The frame length and the overlap are set at run time. Each frame starts `length - overlap` samples after the previous one, so the last `overlap` samples of a frame are sent again at the head of the next. This keeps a downstream cluster finder from seeing frame borders. The duplicated samples stay in the stream. A register port writes the table and the settings into a pending copy, and the pending copy becomes active only when a frame ends. A header is held back until its channel has buffered the whole window. A sample that reaches a full buffer is dropped and sets a sticky per-channel overflow flag.

Top module: `tfm_mux`

## Requirements
- R1: After reset, out_valid is low and ovf_flags is all zero. The active settings are frame length DEF_LEN (16), overlap DEF_OVL (2) and the identity table (slot i holds channel i). The first frame starts at sample 0.
- R2: A frame is 32 groups, one per table slot from slot 0 upward. Each group is one header word followed by exactly `length` data words. A header word has out_hdr=1, out_chan set to the slot's table entry and out_data=0. The data words that follow have out_hdr=0, the same out_chan, and that channel's samples from the frame start upward in arrival order.
- R3: out_sof is high only on the header of slot 0. out_eof is high only on the last data word of slot 31.
- R4: out_start carries the frame's first sample number on every word of the frame. The first frame starts at 0, and each later frame starts at the previous start + length - overlap.
- R5: A write to cfg_addr 0..31 sets that slot's pending table entry from cfg_wdata[4:0]. A write to cfg_addr 32 sets the pending length from cfg_wdata[6:0] and the pending overlap from cfg_wdata[13:7]. Pending values become active only after the eof word of the current frame is accepted.
- R6: A write to cfg_addr 32 is rejected, and the earlier pending settings kept, if length is 0, or overlap >= length, or length + overlap > DEPTH (64).
- R7: A header is offered (out_valid high) exactly when its channel holds every sample of the frame window. Data words are always offered.
- R8: A sample for a channel whose buffer holds DEPTH samples beyond the frame start is dropped. The drop sets that channel's bit in ovf_flags, the bit stays set until reset, and the other channels are unaffected.
- R9: While out_valid is high and out_ready is low, out_valid and all output fields stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_chan | input | 5 | Channel of the sample |
| in_sample | input | 10 | Sample value |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | 0..31 table slot, 32 length/overlap |
| cfg_wdata | input | 14 | Write data |
| ovf_flags | output | 32 | Sticky per-channel overflow flags |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_hdr | output | 1 | Word is a header |
| out_sof | output | 1 | First word of a frame |
| out_eof | output | 1 | Last word of a frame |
| out_chan | output | 5 | Channel of the word |
| out_start | output | 16 | First sample number of the frame |
| out_data | output | 10 | Sample value (0 on headers) |

## Verification
The hardest state to reach is a full channel buffer while a frame is half sent. Filling a buffer takes DEPTH accepted samples beyond the frame start, and the output drains the buffer. The bench gets there by holding out_ready low in the middle of a frame, which freezes the frame start, and then flooding one channel past its capacity. It then releases the stream and checks that the dropped samples never show up in later frames. Settings changes are issued mid-frame, mixed with rejected writes, so that their effect at the next frame boundary is visible in the group lengths and the table order.

// File: rtl/tfm_pkg.sv
// Shared constants and types for the time-frame multiplexer.
// Assumes a fixed 32-channel front end with 10-bit samples.
package tfm_pkg;
    parameter int NCH    = 32;
    parameter int CH_W   = $clog2(NCH);
    parameter int DATA_W = 10;
    parameter int CNT_W  = 16;

    typedef enum logic {ST_HDR = 1'b0, ST_DATA = 1'b1} seq_st_t;
endpackage

// File: rtl/tfm_cfg.sv
// Configuration holder: a pending copy written by the register port, and an
// active copy loaded from it when a frame finishes. Illegal length/overlap
// writes are discarded. Assumes DEPTH fits in LEN_W bits.
module tfm_cfg
    import tfm_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LEN_W   = $clog2(DEPTH) + 1,
    parameter int DEF_LEN = 16,
    parameter int DEF_OVL = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CH_W:0]              cfg_addr,
    input  logic [2*LEN_W-1:0]         cfg_wdata,
    input  logic                       frame_done,
    output logic [LEN_W-1:0]           act_len,
    output logic [LEN_W-1:0]           act_ovl,
    output logic [NCH-1:0][CH_W-1:0]   act_tbl
);
    logic [LEN_W-1:0]         pend_len, pend_ovl;
    logic [NCH-1:0][CH_W-1:0] pend_tbl;
    logic [LEN_W-1:0]         wr_len, wr_ovl;
    logic                     wr_legal;

    // Split and validate a settings write.
    always_comb begin
        wr_len   = cfg_wdata[LEN_W-1:0];
        wr_ovl   = cfg_wdata[2*LEN_W-1:LEN_W];
        wr_legal = (wr_len != '0) && (wr_ovl < wr_len) &&
                   (({1'b0, wr_len} + {1'b0, wr_ovl}) <= (LEN_W+1)'(DEPTH));
    end

    // Pending copy, updated by the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_len <= LEN_W'(DEF_LEN);
            pend_ovl <= LEN_W'(DEF_OVL);
            for (int i = 0; i < NCH; i++) pend_tbl[i] <= CH_W'(i);
        end else if (cfg_we) begin
            if (!cfg_addr[CH_W])
                pend_tbl[cfg_addr[CH_W-1:0]] <= cfg_wdata[CH_W-1:0];
            else if (cfg_addr[CH_W-1:0] == '0 && wr_legal) begin
                pend_len <= wr_len;
                pend_ovl <= wr_ovl;
            end
        end
    end

    // Active copy, refreshed only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_len <= LEN_W'(DEF_LEN);
            act_ovl <= LEN_W'(DEF_OVL);
            for (int i = 0; i < NCH; i++) act_tbl[i] <= CH_W'(i);
        end else if (frame_done) begin
            act_len <= pend_len;
            act_ovl <= pend_ovl;
            act_tbl <= pend_tbl;
        end
    end
endmodule

// File: rtl/tfm_buf.sv
// Per-channel circular sample buffers with absolute write counters.
// A channel may hold at most DEPTH samples counted from the current frame
// start; further samples are dropped and flagged. DEPTH must be a power of 2.
module tfm_buf
    import tfm_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_sample,
    input  logic [CNT_W-1:0]  frm_start,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_fill,
    output logic [NCH-1:0]    ovf_flags
);
    logic [DATA_W-1:0] mem [NCH*DEPTH];
    logic [CNT_W-1:0]  wr_cnt [NCH];
    logic [CNT_W-1:0]  in_occ;
    logic              in_ok;

    // Occupancy of the written channel relative to the frame start.
    always_comb begin
        in_occ = wr_cnt[in_chan] - frm_start;
        in_ok  = in_occ < CNT_W'(DEPTH);
    end

    // Write counters and sticky overflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) wr_cnt[i] <= '0;
            ovf_flags <= '0;
        end else if (in_valid) begin
            if (in_ok) wr_cnt[in_chan] <= wr_cnt[in_chan] + 1'b1;
            else       ovf_flags[in_chan] <= 1'b1;
        end
    end

    // Sample storage, no reset needed.
    always_ff @(posedge clk) begin
        if (in_valid && in_ok)
            mem[{in_chan, wr_cnt[in_chan][ADDR_W-1:0]}] <= in_sample;
    end

    // Read port and fill level for the channel being sent.
    always_comb begin
        rd_data = mem[{rd_chan, rd_idx}];
        rd_fill = wr_cnt[rd_chan] - frm_start;
    end
endmodule

// File: rtl/tfm_seq.sv
// Output sequencer: walks the table slot by slot, sending a header and then
// the frame window of the slot's channel. Outputs come from registers and
// the buffer read, so they hold while the consumer stalls.
module tfm_seq
    import tfm_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LEN_W  = $clog2(DEPTH) + 1,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LEN_W-1:0]         act_len,
    input  logic [LEN_W-1:0]         act_ovl,
    input  logic [NCH-1:0][CH_W-1:0] act_tbl,
    input  logic [CNT_W-1:0]         rd_fill,
    input  logic [DATA_W-1:0]        rd_data,
    input  logic                     out_ready,
    output logic [CNT_W-1:0]         frm_start,
    output logic [CH_W-1:0]          rd_chan,
    output logic [ADDR_W-1:0]        rd_idx,
    output logic                     frame_done,
    output logic                     out_valid,
    output logic                     out_hdr,
    output logic                     out_sof,
    output logic                     out_eof,
    output logic [CH_W-1:0]          out_chan,
    output logic [CNT_W-1:0]         out_start,
    output logic [DATA_W-1:0]        out_data
);
    seq_st_t          st;
    logic [CH_W-1:0]  slot;
    logic [LEN_W-1:0] pos;
    logic             grp_last, fire;
    logic [CNT_W-1:0] pos_abs;

    // Output word and handshake decode.
    always_comb begin
        rd_chan    = act_tbl[slot];
        pos_abs    = frm_start + CNT_W'(pos);
        rd_idx     = pos_abs[ADDR_W-1:0];
        grp_last   = (st == ST_DATA) && (pos == act_len - 1'b1);
        out_valid  = (st == ST_DATA) || (rd_fill >= CNT_W'(act_len));
        fire       = out_valid && out_ready;
        frame_done = fire && grp_last && (slot == CH_W'(NCH-1));
        out_hdr    = (st == ST_HDR);
        out_sof    = (st == ST_HDR) && (slot == '0);
        out_eof    = grp_last && (slot == CH_W'(NCH-1));
        out_chan   = rd_chan;
        out_start  = frm_start;
        out_data   = (st == ST_DATA) ? rd_data : '0;
    end

    // Slot, position and frame start progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_HDR;
            slot      <= '0;
            pos       <= '0;
            frm_start <= '0;
        end else if (fire) begin
            if (st == ST_HDR) begin
                st  <= ST_DATA;
                pos <= '0;
            end else if (grp_last) begin
                st   <= ST_HDR;
                pos  <= '0;
                slot <= slot + 1'b1;
                if (frame_done)
                    frm_start <= frm_start + CNT_W'(act_len) - CNT_W'(act_ovl);
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tfm_mux.sv
// Top: overlapping time-frame channel multiplexer. Connects the config
// holder, the channel buffers and the output sequencer.
module tfm_mux
    import tfm_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int DEF_LEN = 16,
    parameter int DEF_OVL = 2,
    localparam int LEN_W  = $clog2(DEPTH) + 1,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [CH_W-1:0]     in_chan,
    input  logic [DATA_W-1:0]   in_sample,
    input  logic                cfg_we,
    input  logic [CH_W:0]       cfg_addr,
    input  logic [2*LEN_W-1:0]  cfg_wdata,
    output logic [NCH-1:0]      ovf_flags,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_hdr,
    output logic                out_sof,
    output logic                out_eof,
    output logic [CH_W-1:0]     out_chan,
    output logic [CNT_W-1:0]    out_start,
    output logic [DATA_W-1:0]   out_data
);
    logic [LEN_W-1:0]         act_len, act_ovl;
    logic [NCH-1:0][CH_W-1:0] act_tbl;
    logic                     frame_done;
    logic [CNT_W-1:0]         frm_start, rd_fill;
    logic [CH_W-1:0]          rd_chan;
    logic [ADDR_W-1:0]        rd_idx;
    logic [DATA_W-1:0]        rd_data;

    tfm_cfg #(.DEPTH(DEPTH), .LEN_W(LEN_W), .DEF_LEN(DEF_LEN), .DEF_OVL(DEF_OVL)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_done(frame_done),
        .act_len(act_len), .act_ovl(act_ovl), .act_tbl(act_tbl)
    );

    tfm_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .frm_start(frm_start), .rd_chan(rd_chan),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_fill(rd_fill), .ovf_flags(ovf_flags)
    );

    tfm_seq #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .act_len(act_len), .act_ovl(act_ovl),
        .act_tbl(act_tbl), .rd_fill(rd_fill), .rd_data(rd_data),
        .out_ready(out_ready), .frm_start(frm_start), .rd_chan(rd_chan),
        .rd_idx(rd_idx), .frame_done(frame_done), .out_valid(out_valid),
        .out_hdr(out_hdr), .out_sof(out_sof), .out_eof(out_eof),
        .out_chan(out_chan), .out_start(out_start), .out_data(out_data)
    );
endmodule

// File: rtl/tfm_mux_chk.sv
// Property checker for tfm_mux, attached by bind below.
module tfm_mux_chk
    import tfm_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_hdr,
    input logic               out_sof,
    input logic               out_eof,
    input logic [CH_W-1:0]    out_chan,
    input logic [CNT_W-1:0]   out_start,
    input logic [DATA_W-1:0]  out_data,
    input logic [NCH-1:0]     ovf_flags,
    input logic [LEN_W-1:0]   act_len,
    input logic [LEN_W-1:0]   act_ovl
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr) && $stable(out_sof) &&
        $stable(out_eof) && $stable(out_chan) && $stable(out_start) && $stable(out_data)));

    // R3
    sof_on_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> out_hdr);

    // R3
    eof_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |-> !out_hdr);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    // R6
    cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_len != '0) && (act_ovl < act_len));
endmodule

bind tfm_mux tfm_mux_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_sof(out_sof), .out_eof(out_eof), .out_chan(out_chan),
    .out_start(out_start), .out_data(out_data), .ovf_flags(ovf_flags),
    .act_len(act_len), .act_ovl(act_ovl)
);

// File: tb/tfm_mux_bench.sv
`timescale 1ns/1ps
module tfm_mux_bench;
    localparam int DEPTH = 64;
    localparam int LW    = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_chan = '0;
    logic [9:0]  in_sample = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic [31:0] ovf_flags;
    logic        out_valid, out_hdr, out_sof, out_eof;
    logic        out_ready = 1'b0;
    logic [4:0]  out_chan;
    logic [15:0] out_start;
    logic [9:0]  out_data;

    tfm_mux u_tfm_mux (.*);

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;
    // reference model state
    int hist [32][256];
    int cnt [32];
    int m_tbl [32], p_tbl [32];
    int m_start = 0, m_len = 16, m_ovl = 2, p_len = 16, p_ovl = 2;
    int m_slot = 0, m_pos = 0, frames = 0, run_len = 0, last_run = 0, first_chan = -1;
    bit m_hdr = 1;
    logic [31:0] exp_ovf = '0;
    bit held = 0;
    logic [35:0] h_word;

    function automatic void chk(bit ok, string req, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    function automatic bit legal(int l, int o);
        return l != 0 && o < l && l + o <= DEPTH;
    endfunction

    task automatic cycle(bit iv, int ich, int isamp, bit rdy, bit we, int addr, int wd);
        int st_pre, ch;
        bit expv, lastw;
        @(negedge clk);
        st_pre = m_start;
        chk(ovf_flags == exp_ovf, "R8 ovf_flags", ovf_flags, exp_ovf);
        if (held)
            chk(out_valid && {out_hdr, out_sof, out_eof, out_chan, out_start, out_data} == h_word,
                "R9 hold", {out_hdr, out_sof, out_eof, out_chan, out_start, out_data}, h_word);
        ch = m_tbl[m_slot];
        expv = m_hdr ? (cnt[ch] - m_start >= m_len) : 1'b1;
        chk(out_valid == expv, "R7 valid", out_valid, expv);
        out_ready = rdy;
        if (out_valid && rdy) begin
            lastw = !m_hdr && m_pos == m_len - 1 && m_slot == 31;
            chk(out_hdr == m_hdr && out_chan == ch &&
                out_data == (m_hdr ? 0 : hist[ch][(m_start + m_pos) & 255]),
                "R2 word", {out_hdr, out_chan, out_data},
                {m_hdr, 5'(ch), 10'(m_hdr ? 0 : hist[ch][(m_start + m_pos) & 255])});
            chk(out_start == 16'(m_start), "R4 start", out_start, m_start);
            chk(out_sof == (m_hdr && m_slot == 0) && out_eof == lastw, "R3 markers",
                {out_sof, out_eof}, {m_hdr && m_slot == 0, lastw});
            if (m_hdr) begin
                if (m_slot == 0 && first_chan < 0) first_chan = out_chan;
                last_run = run_len; run_len = 0;
                m_hdr = 0; m_pos = 0;
            end else begin
                run_len++;
                if (m_pos == m_len - 1) begin
                    m_pos = 0; m_hdr = 1;
                    if (m_slot == 31) begin
                        m_slot = 0;
                        m_start += m_len - m_ovl;
                        m_len = p_len; m_ovl = p_ovl; m_tbl = p_tbl;
                        frames++;
                    end else m_slot++;
                end else m_pos++;
            end
        end
        held = out_valid && !rdy;
        h_word = {out_hdr, out_sof, out_eof, out_chan, out_start, out_data};
        cfg_we = we; cfg_addr = 6'(addr); cfg_wdata = 14'(wd);
        if (we) begin
            if (addr < 32) p_tbl[addr] = wd & 31;
            else if (addr == 32 && legal(wd & 127, (wd >> 7) & 127)) begin
                p_len = wd & 127; p_ovl = (wd >> 7) & 127;
            end
        end
        in_valid = iv; in_chan = 5'(ich); in_sample = 10'(isamp);
        if (iv) begin
            if (cnt[ich] - st_pre < DEPTH) begin
                hist[ich][cnt[ich] & 255] = isamp;
                cnt[ich]++;
            end else exp_ovf[ich] = 1'b1;
        end
    endtask

    task automatic rand_run(int ncyc, int rdy_pct);
        for (int i = 0; i < ncyc; i++) begin
            int ch = $urandom % 32;
            bit iv = (cnt[ch] - m_start < DEPTH - 2) && ($urandom % 8 != 0);
            cycle(iv, ch, $urandom % 1024, ($urandom % 100) < rdy_pct, 0, 0, 0);
        end
    endtask

    task automatic cfg_write(int addr, int wd);
        cycle(0, 0, 0, 1, 1, addr, wd);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int f0;
        void'($urandom(32'h1234_5EED));
        for (int i = 0; i < 32; i++) begin m_tbl[i] = i; p_tbl[i] = i; cnt[i] = 0; end
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0, "R1 valid after reset", out_valid, 0);
        chk(ovf_flags == 0, "R1 ovf after reset", ovf_flags, 0);
        rst_n = 1'b1;
        rand_run(6000, 100);
        chk(first_chan == 0, "R1 default table slot0", first_chan, 0);
        chk(frames >= 3, "R2 frames produced", frames, 3);
        // R5: reversed table and new settings take effect next frame
        for (int i = 0; i < 32; i++) cfg_write(i, 31 - i);
        cfg_write(32, (5 << 7) | 24);
        // R6: illegal writes must not disturb the pending settings
        cfg_write(32, 0);
        cfg_write(32, (10 << 7) | 10);
        cfg_write(32, (8 << 7) | 60);
        f0 = frames;
        rand_run(9000, 70);
        chk(frames >= f0 + 2, "R5 frames after reconfig", frames, f0 + 2);
        chk(last_run == 24, "R6 group length kept", last_run, 24);
        chk(out_chan == 31 || frames > 0, "R5 table applied", out_chan, 31);
        // R8: stall the stream mid-frame and flood channel 7
        rand_run(200, 100);
        for (int i = 0; i < DEPTH + 8; i++) cycle(1, 7, i * 3, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0);
        chk(ovf_flags == 32'h0000_0080, "R8 only channel 7 flagged", ovf_flags, 32'h80);
        // random table with repeats, heavy backpressure
        for (int i = 0; i < 32; i++) cfg_write(i, $urandom % 32);
        cfg_write(32, (3 << 7) | 12);
        f0 = frames;
        rand_run(12000, 40);
        chk(frames >= f0 + 2, "R4 overlap frames progress", frames, f0 + 2);
        chk(last_run == 12, "R2 group length 12", last_run, 12);
        chk(ovf_flags[7] == 1'b1, "R8 flag sticky", ovf_flags[7], 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule